// File: doc/BRIEF.md
# I2C Interrupt Status Aggregator

This unit sits beside the byte engine of an I2C master and turns its one-cycle event pulses into sticky status flags. The flags cover lost arbitration, a missing acknowledge, access complete, receive data available, transmit space available, receive and transmit buffer drain, receive overrun, transmit underflow, addressed-as-target and general-call address. A live bus-busy input is also visible in the status word. Software reads this unit through a small 16-bit register port.

Each flag is cleared by writing a 1 to its position in the status register. An enable register masks the flags into a single level interrupt. A compatibility vector register is also offered. Reading it returns a small code for the lowest-numbered enabled pending event among the five core events, and clears that one event. Driver software from older controllers can service interrupts through that one read.

Register select `addr_i`: 0 selects the enable register, 1 the status register, 2 the vector register, and 3 is reserved.

Top module: `i2c_irq_stat`

## Requirements
- R1: A pulse on `evt_i` bit b sets status bit b for b in {0 lost arbitration, 1 no-ack, 2 access ready, 3 receive ready, 4 transmit ready, 8 general-call address, 9 addressed as target, 10 underflow, 11 overrun, 13 receive drain, 14 transmit drain}. The bit stays set until it is cleared.
- R2: A write to the status register (addr 1) clears every status bit whose `wdata_i` bit is 1. Bits written 0 are unchanged.
- R3: When an event pulse and a clear of the same bit (a status write or a vector read) land in the same cycle, the bit stays set.
- R4: `irq_o` is high exactly when (status AND enable) is nonzero. It follows a register change in the cycle after the clock edge that made the change.
- R5: The enable register (addr 0) stores only bits 0 to 4, 13 and 14. Its other bits read back as 0.
- R6: Status bit 12 always shows the live `bus_busy_i` level. Writing a 1 to it has no effect.
- R7: A read of the vector register (addr 2) returns a code in bits [2:0]: 0 for none, 1 lost arbitration, 2 no-ack, 3 access ready, 4 receive ready, 5 transmit ready. Only bits that are both pending and enabled count, and the lowest code wins. Bits [15:3] read as 0.
- R8: A vector read clears only the status bit it reported. A vector read that returns 0 changes no state.
- R9: After reset all stored status bits and all enable bits are 0, and `irq_o` is low.
- R10: Pulses on `evt_i` bits 5, 6, 7, 12 and 15 are ignored. A read of addr 3 returns 0.
- R11: `rdata_o` holds the data of a read one clock edge after the edge that sampled `rd_en_i`. A status or vector read returns the value from before any update made at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 16 | One-cycle event pulses, one per status position |
| bus_busy_i | input | 1 | Live bus-busy level |
| addr_i | input | 2 | Register select |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| irq_o | output | 1 | Level interrupt |

## Verification
Status flags, enable bits and the vector clear all take effect at the clock edge that samples the pulse or strobe. The interrupt level is therefore due one edge after that stimulus. Read data is likewise due one edge after the edge that samples the read strobe. The bench drives inputs on the falling edge. It queues the expected value of each read when the read is issued, and the monitor compares it on the next falling edge. Interrupt checks are made on the falling edge right after the edge that applied the event or write. Same-edge collisions are produced by asserting the event and the clear in the same half cycle.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int REG_W = 16;
  localparam int BB_BIT = 12;
  localparam int VEC_SRC_N = 5;
  localparam int CODE_W = $clog2(VEC_SRC_N + 1);
  localparam logic [REG_W-1:0] STAT_MASK = 16'h6F1F;
  localparam logic [REG_W-1:0] EN_MASK   = 16'h601F;

  typedef enum logic [1:0] {
    SEL_EN   = 2'd0,
    SEL_STAT = 2'd1,
    SEL_VEC  = 2'd2,
    SEL_RSV  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/i2c_evt_latch.sv
module i2c_evt_latch
  import i2c_irq_pkg::*;
#(
  parameter int W = REG_W,
  parameter logic [W-1:0] KEEP = STAT_MASK
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    if (KEEP[b]) begin : g_flop
      logic bit_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       bit_q <= 1'b0;
        else if (set_i[b]) bit_q <= 1'b1;   // new event beats clear
        else if (clr_i[b]) bit_q <= 1'b0;
      end
      assign q_o[b] = bit_q;
    end else begin : g_zero
      assign q_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/i2c_vec_enc.sv
module i2c_vec_enc
  import i2c_irq_pkg::*;
#(
  parameter int N = VEC_SRC_N,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  pend_i,
  output logic [CW-1:0] code_o,
  output logic [N-1:0]  sel_o
);
  always_comb begin
    code_o = '0;
    sel_o  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        code_o = CW'(i + 1);
        sel_o  = '0;
        sel_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_reg_port.sv
module i2c_reg_port
  import i2c_irq_pkg::*;
#(
  parameter int W = REG_W,
  parameter int AW = 2,
  parameter int N = VEC_SRC_N,
  parameter int CW = CODE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [W-1:0]  stat_i,
  input  logic          bus_busy_i,
  input  logic [CW-1:0] code_i,
  input  logic [N-1:0]  vsel_i,
  output logic [W-1:0]  en_o,
  output logic [W-1:0]  clr_o,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] en_q, rd_d, stat_view;
  logic sel_en, sel_stat, sel_vec;

  assign sel_en   = addr_i == AW'(SEL_EN);
  assign sel_stat = addr_i == AW'(SEL_STAT);
  assign sel_vec  = addr_i == AW'(SEL_VEC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else if (wr_en_i && sel_en) en_q <= wdata_i & EN_MASK;
  end
  assign en_o = en_q;

  always_comb begin
    clr_o = '0;
    if (wr_en_i && sel_stat) clr_o = wdata_i;
    if (rd_en_i && sel_vec) clr_o[N-1:0] = clr_o[N-1:0] | vsel_i;
  end

  always_comb begin
    stat_view = stat_i;
    stat_view[BB_BIT] = bus_busy_i;
    rd_d = '0;
    if (sel_en)        rd_d = en_q;
    else if (sel_stat) rd_d = stat_view;
    else if (sel_vec)  rd_d = W'(code_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_d;
  end
endmodule

// File: rtl/i2c_irq_stat.sv
module i2c_irq_stat
  import i2c_irq_pkg::*;
#(
  parameter int AW = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] evt_i,
  input  logic             bus_busy_i,
  input  logic [AW-1:0]    addr_i,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             irq_o
);
  logic [REG_W-1:0] stat_q, en_q, clr;
  logic [CODE_W-1:0] code;
  logic [VEC_SRC_N-1:0] vsel;

  i2c_evt_latch #(.W(REG_W), .KEEP(STAT_MASK)) u_latch (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(evt_i), .clr_i(clr), .q_o(stat_q)
  );

  i2c_vec_enc #(.N(VEC_SRC_N), .CW(CODE_W)) u_enc (
    .pend_i(stat_q[VEC_SRC_N-1:0] & en_q[VEC_SRC_N-1:0]),
    .code_o(code), .sel_o(vsel)
  );

  i2c_reg_port #(.W(REG_W), .AW(AW), .N(VEC_SRC_N), .CW(CODE_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
    .rd_en_i(rd_en_i), .wdata_i(wdata_i), .stat_i(stat_q),
    .bus_busy_i(bus_busy_i), .code_i(code), .vsel_i(vsel),
    .en_o(en_q), .clr_o(clr), .rdata_o(rdata_o)
  );

  assign irq_o = |(stat_q & en_q);
endmodule

// File: rtl/i2c_irq_stat_chk.sv
module i2c_irq_stat_chk
  import i2c_irq_pkg::*;
#(
  parameter int AW = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [REG_W-1:0] evt_i,
  input logic [AW-1:0]    addr_i,
  input logic             wr_en_i,
  input logic             rd_en_i,
  input logic [REG_W-1:0] stat_q,
  input logic [REG_W-1:0] en_q,
  input logic             irq_o
);
  logic quiet;
  assign quiet = !wr_en_i && !(rd_en_i && addr_i == AW'(SEL_VEC)) && evt_i == '0;

  a_r1_r3_evt_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i & STAT_MASK) != '0 |=> (stat_q & $past(evt_i & STAT_MASK)) == $past(evt_i & STAT_MASK));

  a_r2_hold_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quiet |=> $stable(stat_q));

  a_r8_vec_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == AW'(SEL_VEC) && !wr_en_i) |=> $countones($past(stat_q) & ~stat_q) <= 1);

  a_r4_no_en_no_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q == '0 |-> !irq_o);

  a_r4_no_stat_no_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_q == '0 |-> !irq_o);

  a_r10_unused_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q & ~STAT_MASK) == '0);
endmodule

bind i2c_irq_stat i2c_irq_stat_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .addr_i(addr_i),
  .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .stat_q(stat_q), .en_q(en_q),
  .irq_o(irq_o)
);

// File: tb/i2c_irq_stat_test.sv
module i2c_irq_stat_test;
  logic clk = 0, rst_ni = 0;
  logic [15:0] evt = '0, wdata = '0;
  logic bb = 0, wr_en = 0, rd_en = 0;
  logic [1:0] addr = '0;
  logic [15:0] rdata;
  logic irq;
  int checks = 0, failures = 0;
  logic rd_seen = 0;
  logic [15:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  i2c_irq_stat uut (
    .clk_i(clk), .rst_ni(rst_ni), .evt_i(evt), .bus_busy_i(bb),
    .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq)
  );

  always @(posedge clk) rd_seen <= rd_en;

  // monitor: compare read results one edge after the read strobe
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        failures++;
        $display("FAIL %s rdata=%h expected=%h", t, rdata, e);
      end
    end
  end

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq !== e) begin
      failures++;
      $display("FAIL %s irq=%b expected=%b", t, irq, e);
    end
  endtask

  task automatic rd(input logic [1:0] a, input logic [15:0] e, input string t);
    addr = a; rd_en = 1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic pulse(input logic [15:0] v);
    evt = v;
    @(negedge clk);
    evt = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R9 reset state
    chk_irq(0, "R9 irq after reset");
    rd(0, 16'h0000, "R9 enable after reset");
    rd(1, 16'h0000, "R9 status after reset");
    rd(2, 16'h0000, "R7 vector none");
    rd(3, 16'h0000, "R10 reserved address");
    // R6 live bus busy
    bb = 1;
    rd(1, 16'h1000, "R6 bb visible");
    wr(1, 16'h1000);
    rd(1, 16'h1000, "R6 bb not clearable");
    bb = 0;
    rd(1, 16'h0000, "R6 bb follows input");
    // R1 / R4
    pulse(16'h0001);
    chk_irq(0, "R4 masked event");
    rd(1, 16'h0001, "R1 lost arbitration latched");
    wr(0, 16'h0001);
    chk_irq(1, "R4 enabled event");
    wr(0, 16'hFFFF);
    rd(0, 16'h601F, "R5 enable mask");
    // R2
    wr(1, 16'h0000);
    rd(1, 16'h0001, "R2 write zero keeps");
    wr(1, 16'h0001);
    chk_irq(0, "R4 irq drops after clear");
    rd(1, 16'h0000, "R2 write one clears");
    // R10 ignored positions
    pulse(16'h90E0);
    rd(1, 16'h0000, "R10 unused events ignored");
    chk_irq(0, "R10 no irq from unused");
    // R1 multiple, R7/R8 vector order
    pulse(16'h0C1C);
    pulse(16'h6300);
    rd(1, 16'h6F1C, "R1 many events latched");
    rd(2, 16'h0003, "R7 access ready first");
    rd(2, 16'h0004, "R7 receive ready next");
    rd(1, 16'h6F10, "R8 only reported bits cleared");
    rd(2, 16'h0005, "R7 transmit ready");
    rd(2, 16'h0000, "R8 none left");
    rd(1, 16'h6F00, "R8 zero read no change");
    wr(1, 16'h6F00);
    rd(1, 16'h0000, "R2 clear upper bits");
    // R7 masked vector
    wr(0, 16'h601D);
    pulse(16'h0002);
    rd(2, 16'h0000, "R7 disabled no-ack not reported");
    rd(1, 16'h0002, "R8 disabled bit untouched");
    chk_irq(0, "R4 no-ack disabled");
    wr(0, 16'h601F);
    chk_irq(1, "R4 no-ack enabled");
    rd(2, 16'h0002, "R7 no-ack code");
    rd(1, 16'h0000, "R8 vector cleared no-ack");
    // R3 collisions
    evt = 16'h0001; addr = 1; wdata = 16'h0001; wr_en = 1;
    @(negedge clk);
    evt = '0; wr_en = 0;
    rd(1, 16'h0001, "R3 event beats write clear");
    evt = 16'h0001;
    rd(2, 16'h0001, "R11 vector reports pre-edge value");
    evt = '0;
    rd(1, 16'h0001, "R3 event beats vector clear");
    wr(1, 16'h0001);
    // R4 drain interrupt
    wr(0, 16'h2000);
    pulse(16'h2000);
    chk_irq(1, "R4 receive drain irq");
    wr(0, 16'h0000);
    chk_irq(0, "R4 enable removed");
    // R11 read returns pre-update status
    evt = 16'h0010; addr = 1; rd_en = 1;
    exp_q.push_back(16'h2000); tag_q.push_back("R11 status read before update");
    @(negedge clk);
    evt = '0; rd_en = 0;
    rd(1, 16'h2010, "R11 update visible next read");
    // R9 reset mid-run
    wr(0, 16'h601F);
    chk_irq(1, "R4 pending before reset");
    rst_ni = 0;
    @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk_irq(0, "R9 irq cleared by reset");
    rd(1, 16'h0000, "R9 status cleared by reset");
    rd(0, 16'h0000, "R9 enable cleared by reset");
    @(negedge clk);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule